// File: doc/BRIEF.md
# Multicycle Shared-Unit Processor Datapath

This block is the datapath of a small 32-bit load/store processor that spends several clock cycles on each instruction. One memory port serves both instruction fetch and data access, and a single ALU performs every addition the instruction needs. That includes the PC increment, the branch target, the effective address and the arithmetic result. Holding registers keep values between cycles. The instruction register, the memory data register, the two operand latches and the result latch let one instruction reuse the same ALU and memory in successive cycles.

An external step sequencer drives the select and write-enable inputs one cycle at a time. It receives back the opcode field, the function field and the ALU zero flag. The memory port has no handshake. Read data must be returned combinationally in the same cycle the address is presented. Writes take effect at the clock edge while the write strobe is high. There is no back-pressure, so a memory that cannot answer within the cycle must be handled by the sequencer holding its state.

Top module: `mcdp_datapath`

## Requirements
- R1: While `rst_n` is low, the PC, instruction register, memory data register, both operand latches, the result latch and all 32 register-file entries are cleared to zero.
- R2: `mem_addr` shows the PC when `addr_sel_data`=0 and the result latch when `addr_sel_data`=1.
- R3: The instruction register captures `mem_rdata` at a clock edge only when `ir_we`=1. `opcode` is bits 31:26 of the instruction register and `funct` is bits 5:0.
- R4: At every clock edge, operand latch A loads register-file entry IR[25:21] and operand latch B loads entry IR[20:16]. `mem_wdata` always shows latch B.
- R5: ALU operand one is the PC when `opa_sel_reg`=0 and latch A when it is 1. For operand two, `opb_sel` value 0 selects B, 1 selects the constant 4, 2 selects the sign-extended IR[15:0], and 3 selects that value shifted left by two. `alu_op` codes are 0 add, 1 subtract, 2 AND, 3 OR and 4 signed set-less-than; any other code gives zero. The result latch captures the ALU result at every edge.
- R6: `alu_zero` is high exactly when the live ALU result is all zeros.
- R7: When `rf_we`=1, the register file writes at the edge. The target is IR[20:16] when `dst_sel_rd`=0 and IR[15:11] when it is 1. The data is the result latch when `wb_sel_mem`=0 and the memory data register when it is 1.
- R8: Register 0 reads as zero whatever is written to it.
- R9: The memory data register captures `mem_rdata` at every clock edge.
- R10: The PC is written at an edge when `pc_we`=1, or when `pc_we_on_zero`=1 and `alu_zero`=1. Otherwise it holds.
- R11: `npc_sel` value 0 loads the PC from the live ALU result, 1 from the result latch, and 2 from the jump target. The jump target is PC[31:28], then IR[25:0], then two zero bits. Value 3 behaves like 0.
- R12: `mem_rd` and `mem_wr` follow `mem_rd_req` and `mem_wr_req` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel_data | input | 1 | Memory address source: 0 PC, 1 result latch |
| opa_sel_reg | input | 1 | ALU operand one: 0 PC, 1 latch A |
| opb_sel | input | 2 | ALU operand two source |
| alu_op | input | 3 | ALU operation code |
| npc_sel | input | 2 | Next-PC source |
| pc_we | input | 1 | Unconditional PC write |
| pc_we_on_zero | input | 1 | PC write when the zero flag is set |
| ir_we | input | 1 | Instruction register load |
| rf_we | input | 1 | Register file write |
| dst_sel_rd | input | 1 | Write target: 0 IR[20:16], 1 IR[15:11] |
| wb_sel_mem | input | 1 | Write data: 0 result latch, 1 memory data register |
| mem_rd_req | input | 1 | Memory read request from the sequencer |
| mem_wr_req | input | 1 | Memory write request from the sequencer |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data (latch B) |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| opcode | output | 6 | Instruction register bits 31:26 |
| funct | output | 6 | Instruction register bits 5:0 |
| alu_zero | output | 1 | Live ALU result is zero |

## Verification
The assertions assume that the control inputs are known (not X) at every clock edge after reset. They also assume that `mem_rdata` is stable before the edge at which it is captured. The bench meets both assumptions by acting as the sequencer. It changes controls only just after an edge and serves reads from an array indexed by `mem_addr`. The bench issues fetch, decode, execute and write-back steps in legal orders. It sweeps every ALU code, including an undefined one, across signed operand pairs. Every result is read back through latch B.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;

  localparam int ALU_OP_W = 3;

  typedef enum logic [ALU_OP_W-1:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_LATCH = 2'd0,
    OPB_FOUR  = 2'd1,
    OPB_IMM   = 2'd2,
    OPB_IMM4  = 2'd3
  } opb_src_e;

  typedef enum logic [1:0] {
    NPC_LIVE = 2'd0,
    NPC_HELD = 2'd1,
    NPC_JUMP = 2'd2,
    NPC_RSVD = 2'd3
  } npc_src_e;

endpackage

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [ALU_OP_W-1:0] op,
  input  logic [WORD_W-1:0]   a,
  input  logic [WORD_W-1:0]   b,
  output logic [WORD_W-1:0]   res,
  output logic                zero
);

  always_comb begin
    case (alu_op_e'(op))
      ALU_ADD: res = a + b;
      ALU_SUB: res = a - b;
      ALU_AND: res = a & b;
      ALU_OR:  res = a | b;
      ALU_SLT: res = {{(WORD_W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: res = '0;
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/mcdp_imm_ext.sv
module mcdp_imm_ext #(
  parameter int IMM_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic [IMM_W-1:0]  imm,
  output logic [WORD_W-1:0] sext,
  output logic [WORD_W-1:0] sext_x4
);

  localparam int FILL_W = WORD_W - IMM_W;

  assign sext    = {{FILL_W{imm[IMM_W-1]}}, imm};
  assign sext_x4 = {sext[WORD_W-3:0], 2'b00};

endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [WORD_W-1:0] rdata_a,
  output logic [WORD_W-1:0] rdata_b
);

  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we && (waddr != '0)) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];

  // R8: entry zero is never observed nonzero on either read port
  assert_zero_entry_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr_a == '0) |-> (rdata_a == '0));
  assert_zero_entry_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr_b == '0) |-> (rdata_b == '0));

endmodule

// File: rtl/mcdp_datapath.sv
module mcdp_datapath
  import mcdp_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int REG_IDX_W = 5,
  parameter int IMM_W     = 16,
  parameter int OPC_W     = 6,
  parameter int FUNCT_W   = 6,
  parameter int JUMP_W    = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel_data,
  input  logic              opa_sel_reg,
  input  logic [1:0]        opb_sel,
  input  logic [2:0]        alu_op,
  input  logic [1:0]        npc_sel,
  input  logic              pc_we,
  input  logic              pc_we_on_zero,
  input  logic              ir_we,
  input  logic              rf_we,
  input  logic              dst_sel_rd,
  input  logic              wb_sel_mem,
  input  logic              mem_rd_req,
  input  logic              mem_wr_req,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [OPC_W-1:0]  opcode,
  output logic [FUNCT_W-1:0] funct,
  output logic              alu_zero
);

  localparam int RS_LSB  = WORD_W - OPC_W - REG_IDX_W;
  localparam int RT_LSB  = RS_LSB - REG_IDX_W;
  localparam int RD_LSB  = RT_LSB - REG_IDX_W;
  localparam int PCHI_W  = WORD_W - JUMP_W - 2;

  logic [WORD_W-1:0] pc_q, instr_q, mdata_q, opa_q, opb_q, res_q;
  logic [WORD_W-1:0] rf_rdata_a, rf_rdata_b, rf_wdata;
  logic [REG_IDX_W-1:0] rf_waddr;
  logic [WORD_W-1:0] alu_a, alu_b, alu_res;
  logic [WORD_W-1:0] imm_sext, imm_sext_x4;
  logic [WORD_W-1:0] jump_tgt, next_pc;
  logic              pc_load;

  // Register file: writes land at the edge, reads are combinational
  assign rf_waddr = dst_sel_rd ? instr_q[RD_LSB +: REG_IDX_W]
                               : instr_q[RT_LSB +: REG_IDX_W];
  assign rf_wdata = wb_sel_mem ? mdata_q : res_q;

  mcdp_regfile #(.WORD_W(WORD_W), .IDX_W(REG_IDX_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (instr_q[RS_LSB +: REG_IDX_W]),
    .raddr_b (instr_q[RT_LSB +: REG_IDX_W]),
    .rdata_a (rf_rdata_a),
    .rdata_b (rf_rdata_b)
  );

  mcdp_imm_ext #(.IMM_W(IMM_W), .WORD_W(WORD_W)) u_imm (
    .imm     (instr_q[IMM_W-1:0]),
    .sext    (imm_sext),
    .sext_x4 (imm_sext_x4)
  );

  // Operand selection for the single shared ALU
  assign alu_a = opa_sel_reg ? opa_q : pc_q;

  always_comb begin
    case (opb_src_e'(opb_sel))
      OPB_LATCH: alu_b = opb_q;
      OPB_FOUR:  alu_b = WORD_W'(4);
      OPB_IMM:   alu_b = imm_sext;
      default:   alu_b = imm_sext_x4;
    endcase
  end

  mcdp_alu #(.WORD_W(WORD_W)) u_alu (
    .op   (alu_op),
    .a    (alu_a),
    .b    (alu_b),
    .res  (alu_res),
    .zero (alu_zero)
  );

  // Next-PC selection and write qualification
  assign jump_tgt = {pc_q[WORD_W-1 -: PCHI_W], instr_q[JUMP_W-1:0], 2'b00};

  always_comb begin
    case (npc_src_e'(npc_sel))
      NPC_HELD: next_pc = res_q;
      NPC_JUMP: next_pc = jump_tgt;
      default:  next_pc = alu_res;
    endcase
  end

  assign pc_load = pc_we | (pc_we_on_zero & alu_zero);

  // Architectural PC and the inter-cycle holding registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      instr_q <= '0;
      mdata_q <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      res_q   <= '0;
    end else begin
      mdata_q <= mem_rdata;
      opa_q   <= rf_rdata_a;
      opb_q   <= rf_rdata_b;
      res_q   <= alu_res;
      if (ir_we)   instr_q <= mem_rdata;
      if (pc_load) pc_q    <= next_pc;
    end
  end

  // Memory port and controller feedback
  assign mem_addr  = addr_sel_data ? res_q : pc_q;
  assign mem_wdata = opb_q;
  assign mem_rd    = mem_rd_req;
  assign mem_wr    = mem_wr_req;
  assign opcode    = instr_q[WORD_W-1 -: OPC_W];
  assign funct     = instr_q[FUNCT_W-1:0];

  // R3: instruction register only changes under its enable
  assert_ir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_we |=> $stable(instr_q));
  assert_ir_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |=> (instr_q == $past(mem_rdata)));

  // R9: memory data register follows the read bus one edge later
  assert_mdr_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (mdata_q == $past(mem_rdata)));

  // R5: result latch holds the previous cycle's ALU output
  assert_result_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (res_q == $past(alu_res)));

  // R6: a subtraction flags zero exactly on equal operands
  assert_sub_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 3'(ALU_SUB)) |-> (alu_zero == (alu_a == alu_b)));

  // R10: PC holds when no write is requested, or the conditional one fails
  assert_pc_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_we && !pc_we_on_zero) |=> $stable(pc_q));
  assert_pc_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_we && pc_we_on_zero && !alu_zero) |=> $stable(pc_q));

  // R11: a jump keeps the upper PC bits and lands word aligned
  assert_jump_region_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && npc_sel == 2'(NPC_JUMP)) |=>
      (pc_q[WORD_W-1 -: PCHI_W] == $past(pc_q[WORD_W-1 -: PCHI_W])) && (pc_q[1:0] == 2'b00));

endmodule

// File: tb/mcdp_datapath_tb.sv
module mcdp_datapath_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic addr_sel_data, opa_sel_reg, pc_we, pc_we_on_zero, ir_we, rf_we;
  logic dst_sel_rd, wb_sel_mem, mem_rd_req, mem_wr_req;
  logic [1:0] opb_sel, npc_sel;
  logic [2:0] alu_op;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_rd, mem_wr, alu_zero;
  logic [5:0] opcode, funct;

  logic [31:0] mem [256];
  logic [31:0] rf_model [32];
  logic [31:0] exp_pc;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:2]];

  mcdp_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .addr_sel_data(addr_sel_data), .opa_sel_reg(opa_sel_reg),
    .opb_sel(opb_sel), .alu_op(alu_op), .npc_sel(npc_sel), .pc_we(pc_we),
    .pc_we_on_zero(pc_we_on_zero), .ir_we(ir_we), .rf_we(rf_we), .dst_sel_rd(dst_sel_rd),
    .wb_sel_mem(wb_sel_mem), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .opcode(opcode), .funct(funct), .alu_zero(alu_zero)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_alu(input int op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic ctl_idle();
    addr_sel_data = 0; opa_sel_reg = 0; opb_sel = 0; alu_op = 0; npc_sel = 0;
    pc_we = 0; pc_we_on_zero = 0; ir_we = 0; rf_we = 0; dst_sel_rd = 0;
    wb_sel_mem = 0; mem_rd_req = 0; mem_wr_req = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic fetch(input logic [31:0] instr);
    mem[exp_pc[9:2]] = instr;
    ctl_idle();
    mem_rd_req = 1; ir_we = 1; opb_sel = 2'd1; pc_we = 1;
    tick();
    exp_pc = exp_pc + 32'd4;
    check("R2 fetch pc", mem_addr, exp_pc);
    check("R3 opcode loaded", {26'd0, opcode}, {26'd0, instr[31:26]});
  endtask

  task automatic decode(input logic [31:0] instr);
    ctl_idle();
    opb_sel = 2'd3;
    tick();
    check("R3 ir held", {20'd0, opcode, funct}, {20'd0, instr[31:26], instr[5:0]});
  endtask

  task automatic read_reg(input int r, output logic [31:0] v);
    logic [31:0] ins;
    ins = {6'h3E, 5'd0, 5'(r), 16'h0000};
    fetch(ins);
    decode(ins);
    v = mem_wdata;
  endtask

  task automatic load_imm(input int rt, input logic [15:0] imm);
    logic [31:0] ins;
    ins = {6'h08, 5'd0, 5'(rt), imm};
    fetch(ins);
    decode(ins);
    ctl_idle(); opa_sel_reg = 1; opb_sel = 2'd2;
    tick();
    ctl_idle(); rf_we = 1;
    tick();
    if (rt != 0) rf_model[rt] = sx(imm);
  endtask

  task automatic rtype(input int rs, input int rt, input int rd, input int op);
    logic [31:0] ins, expv, got;
    ins = {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
    fetch(ins);
    decode(ins);
    expv = ref_alu(op, rf_model[rs], rf_model[rt]);
    ctl_idle(); opa_sel_reg = 1; opb_sel = 2'd0; alu_op = 3'(op);
    #1;
    check("R6 zero flag", {31'd0, alu_zero}, {31'd0, expv == 32'd0});
    tick();
    ctl_idle(); addr_sel_data = 1;
    #1;
    check("R5 alu result via R2 data address", mem_addr, expv);
    rf_we = 1; dst_sel_rd = 1;
    tick();
    if (rd != 0) rf_model[rd] = expv;
    read_reg(rd, got);
    check("R7 rd write back / R8", got, (rd == 0) ? 32'd0 : expv);
  endtask

  initial begin
    logic [31:0] v, ins, saddr, sdata;
    logic [15:0] pa [6];
    logic [15:0] pb [6];
    pa = '{16'd7, 16'hFFFD, 16'd5, 16'h7FFF, 16'hFFFF, 16'd0};
    pb = '{16'd3, 16'd5, 16'd5, 16'h8000, 16'hFFFF, 16'd1};
    for (int i = 0; i < 256; i++) mem[i] = 32'hFFFF_FFFF;
    for (int i = 0; i < 32; i++) rf_model[i] = 32'd0;
    mem[240] = 32'hA5A5_1234;
    exp_pc = 32'd0;
    ctl_idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1: reset state at the ports
    check("R1 pc reset", mem_addr, 32'd0);
    check("R1 B latch reset", mem_wdata, 32'd0);
    check("R1 ir reset", {20'd0, opcode, funct}, 32'd0);
    addr_sel_data = 1;
    #1;
    check("R1 result latch reset", mem_addr, 32'd0);
    addr_sel_data = 0;
    read_reg(5, v);
    check("R1 regfile reset", v, 32'd0);

    // R5 R6 R7: sweep every ALU code over signed operand pairs
    for (int p = 0; p < 6; p++) begin
      load_imm(1, pa[p]);
      load_imm(2, pb[p]);
      read_reg(1, v);
      check("R7 rt write back / R4", v, sx(pa[p]));
      for (int op = 0; op < 6; op++) rtype(1, 2, 3, op);
    end

    // R8: register 0 stays zero
    load_imm(0, 16'h1234);
    read_reg(0, v);
    check("R8 r0 after immediate", v, 32'd0);
    rtype(1, 2, 0, 3);

    // R9 R7 R12: load through the memory data register
    ins = {6'h23, 5'd0, 5'd6, 16'h03C0};
    fetch(ins); decode(ins);
    ctl_idle(); opa_sel_reg = 1; opb_sel = 2'd2; tick();
    ctl_idle(); addr_sel_data = 1; mem_rd_req = 1;
    #1;
    check("R12 read strobe", {31'd0, mem_rd}, 32'd1);
    check("R2 data address", mem_addr, 32'h3C0);
    tick();
    ctl_idle(); rf_we = 1; wb_sel_mem = 1; tick();
    read_reg(6, v);
    check("R9 loaded word", v, 32'hA5A5_1234);

    // R12 R4: store of register 1
    load_imm(1, 16'h8421);
    ins = {6'h2B, 5'd0, 5'd1, 16'h03C8};
    fetch(ins); decode(ins);
    ctl_idle(); opa_sel_reg = 1; opb_sel = 2'd2; tick();
    ctl_idle(); addr_sel_data = 1; mem_wr_req = 1;
    #1;
    check("R12 write strobe", {31'd0, mem_wr}, 32'd1);
    check("R12 store address", mem_addr, 32'h3C8);
    check("R4 store data", mem_wdata, 32'hFFFF_8421);
    saddr = mem_addr; sdata = mem_wdata;
    tick();
    if (mem_wr_req) mem[saddr[9:2]] = sdata;
    ctl_idle();
    #1;
    check("R12 strobe released", {30'd0, mem_rd, mem_wr}, 32'd0);

    // R10 R11: conditional branch taken and not taken
    load_imm(1, 16'd9);
    load_imm(2, 16'd9);
    ins = {6'h04, 5'd1, 5'd2, 16'h0010};
    fetch(ins); decode(ins);
    ctl_idle(); opa_sel_reg = 1; alu_op = 3'd1; npc_sel = 2'd1; pc_we_on_zero = 1;
    #1;
    check("R6 equal operands", {31'd0, alu_zero}, 32'd1);
    tick();
    ctl_idle(); #1;
    exp_pc = exp_pc + 32'd64;
    check("R10 branch taken", mem_addr, exp_pc);
    load_imm(2, 16'd8);
    fetch(ins); decode(ins);
    ctl_idle(); opa_sel_reg = 1; alu_op = 3'd1; npc_sel = 2'd1; pc_we_on_zero = 1;
    tick();
    ctl_idle(); #1;
    check("R10 branch not taken", mem_addr, exp_pc);

    // R11: live result into PC, then jump keeping the upper nibble
    load_imm(3, 16'hFF00);
    ins = {6'h3E, 5'd3, 5'd0, 16'h0080};
    fetch(ins); decode(ins);
    ctl_idle(); opa_sel_reg = 1; opb_sel = 2'd2; pc_we = 1;
    tick();
    ctl_idle(); #1;
    exp_pc = 32'hFFFF_FF80;
    check("R11 live result to pc", mem_addr, exp_pc);
    ins = {6'h02, 26'h0000040};
    fetch(ins); decode(ins);
    ctl_idle(); npc_sel = 2'd2; pc_we = 1;
    tick();
    ctl_idle(); #1;
    check("R11 jump target", mem_addr, 32'hF000_0100);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule